// File: doc/BRIEF.md
# Adaptive Replication Level Controller

This block sets the replication level for one processor's private second-level cache. The level is a small integer from 0 to 5, and the writeback steering logic reads it at run time. Four hit strobes feed four estimators. Two estimate benefit: hits on blocks that are replicas at the current level (benefit lost if the level drops), and hits in the next-level partial-tag buffer (benefit gained if it rises). Two estimate cost: hits in the victim tag buffer (misses saved if the level drops), and hits on the least-recently-used positions of the 16-way pseudo-LRU order (misses added if it rises). The tag buffers themselves live outside this block and appear here only as strobes.

Evaluations are paced by a separate pair of allocation strobes: local replications and next-level-buffer allocations. Once enough of them have arrived, the block weighs the four event totals. Benefit events are weighted by the remote-minus-local hit latency. Cost events are weighted by the memory miss penalty. The result is a vote to decrease, increase or hold. The level moves one step only after a streak of agreeing votes. When it moves, a one-cycle pulse accompanies the new level.

A control FSM sequences each evaluation through three states:
- `ST_COLLECT` gathers events. It goes to `ST_WEIGH` when the allocation threshold is met (transition *window close*).
- `ST_WEIGH` registers the four weighted products, then always goes to `ST_VOTE` (transition *products ready*).
- `ST_VOTE` applies the vote to the streak and the level, then always returns to `ST_COLLECT` (transition *vote applied*).

Top module: `repl_level_ctrl`

## Requirements
- R1: During and after reset, `repl_level` is `RESET_LEVEL` (0 by default), `level_update` is low, and no streak is held.
- R2: An evaluation window closes in the cycle where the combined count of sampled allocation strobes reaches `TRIG_COUNT` (1024). Both strobes high in one cycle count as two. The count restarts from zero after each closure.
- R3: A vote is computed from the window totals:
  - `want_dec` is true when victim-hits × `miss_penalty` > replica-hits × `hit_lat_delta`.
  - `want_inc` is true when next-buffer-hits × `hit_lat_delta` > LRU-tail-hits × `miss_penalty`.
  - The vote is decrease when only `want_dec` holds, increase when only `want_inc` holds, and hold otherwise (neither, both, or equality).
- R4: The level moves by exactly one step in the vote's direction when `STREAK_LEN` (4) consecutive effective votes agree. After a move the streak is empty.
- R5: A hold vote empties the streak. A vote opposite to the current streak starts a new streak of length one.
- R6: The level stays within 0..`MAX_LEVEL` (5). A decrease vote at 0 or an increase vote at `MAX_LEVEL` is ignored and leaves the streak unchanged.
- R7: A level change takes effect two clock cycles after the cycle in which the window closes. In that cycle `level_update` is high for exactly one cycle. The level never changes without this pulse.
- R8: A hit strobe sampled in the closing cycle counts toward the closing window. Hits sampled later count toward the next window, and event totals start from zero for each window.
- R9: Each event total saturates at 2^`CNT_W`−1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_cur_replica | input | 1 | Hit on a block replicated at the current level |
| hit_next_buf | input | 1 | Hit in the next-level partial-tag buffer |
| hit_victim_buf | input | 1 | Hit in the victim tag buffer |
| hit_lru_tail | input | 1 | Hit on a soon-to-be-evicted pseudo-LRU position |
| alloc_local_repl | input | 1 | A local replication was made |
| alloc_next_buf | input | 1 | A next-level buffer entry was allocated |
| hit_lat_delta | input | LAT_W | Remote-minus-local hit latency weight |
| miss_penalty | input | LAT_W | Memory miss latency weight |
| repl_level | output | LVL_W | Current replication level |
| level_update | output | 1 | One-cycle pulse with a new level |

## Verification
Two functions can act in the same cycle: closing a window, and counting a hit strobe. The bench builds a streak of three decrease votes. It then sends a window of 1023 allocations with no hits and checks that no evaluation has run. Finally it raises the last allocation together with a single victim-buffer hit. If that hit is counted into the closing window, the fourth decrease vote completes the streak and the level drops. If the hit is lost or deferred, the vote is hold and the level stays put.

// File: rtl/repl_lvl_pkg.sv
package repl_lvl_pkg;

    typedef enum logic [1:0] {
        VOTE_HOLD = 2'd0,
        VOTE_DEC  = 2'd1,
        VOTE_INC  = 2'd2
    } vote_e;

    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_WEIGH   = 2'd1,
        ST_VOTE    = 2'd2
    } ctl_state_e;

    // Event slot indices
    localparam int EV_BEN_LOSS  = 0;  // replica hits: benefit lost by lowering
    localparam int EV_BEN_GAIN  = 1;  // next-level buffer hits: benefit gained by raising
    localparam int EV_COST_SAVE = 2;  // victim buffer hits: misses saved by lowering
    localparam int EV_COST_ADD  = 3;  // LRU tail hits: misses added by raising
    localparam int NUM_EV       = 4;

endpackage

// File: rtl/repl_event_ctr.sv
module repl_event_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev,
    input  logic             close_win,
    output logic [CNT_W-1:0] win_total
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_inc;

    // saturating increment, includes the strobe of the current cycle
    always_comb begin
        if (ev && (run_q != CNT_MAX)) run_inc = run_q + 1'b1;
        else                          run_inc = run_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= '0;
            win_total <= '0;
        end else if (close_win) begin
            win_total <= run_inc;
            run_q     <= '0;
        end else begin
            run_q     <= run_inc;
        end
    end
endmodule

// File: rtl/repl_eval_trigger.sv
module repl_eval_trigger #(
    parameter int TRIG_COUNT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alloc_a,
    input  logic alloc_b,
    input  logic armed,
    output logic fire
);
    localparam int AW = $clog2(TRIG_COUNT + 2) + 1;
    localparam logic [AW-1:0] TRIG_V = AW'(TRIG_COUNT);

    logic [AW-1:0] acc_q;
    logic [AW-1:0] acc_sum;

    always_comb begin
        acc_sum = acc_q + AW'(alloc_a) + AW'(alloc_b);
        fire    = armed && (acc_sum >= TRIG_V);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                acc_q <= '0;
        else if (fire)             acc_q <= '0;
        else if (acc_sum >= TRIG_V) acc_q <= TRIG_V;   // wait for FSM to re-arm
        else                       acc_q <= acc_sum;
    end
endmodule

// File: rtl/repl_vote_unit.sv
module repl_vote_unit
    import repl_lvl_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LAT_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           weigh_en,
    input  logic [NUM_EV-1:0][CNT_W-1:0]   win_cnt,
    input  logic [LAT_W-1:0]               hit_lat,
    input  logic [LAT_W-1:0]               miss_lat,
    output vote_e                          vote
);
    localparam int PW = CNT_W + LAT_W;

    logic [NUM_EV-1:0][PW-1:0] prod_q;

    for (genvar g = 0; g < NUM_EV; g++) begin : g_weigh
        // benefit slots take the hit latency, cost slots the miss penalty
        logic [LAT_W-1:0] wt;
        if (g == EV_BEN_LOSS || g == EV_BEN_GAIN) begin : g_ben
            assign wt = hit_lat;
        end else begin : g_cost
            assign wt = miss_lat;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)        prod_q[g] <= '0;
            else if (weigh_en) prod_q[g] <= PW'(win_cnt[g]) * PW'(wt);
        end
    end

    logic want_dec;
    logic want_inc;

    always_comb begin
        want_dec = prod_q[EV_COST_SAVE] > prod_q[EV_BEN_LOSS];
        want_inc = prod_q[EV_BEN_GAIN]  > prod_q[EV_COST_ADD];
        if (want_dec && !want_inc)      vote = VOTE_DEC;
        else if (want_inc && !want_dec) vote = VOTE_INC;
        else                            vote = VOTE_HOLD;
    end
endmodule

// File: rtl/repl_streak_ctrl.sv
module repl_streak_ctrl
    import repl_lvl_pkg::*;
#(
    parameter int LVL_W       = 3,
    parameter int MAX_LEVEL   = 5,
    parameter int RESET_LEVEL = 0,
    parameter int STREAK_LEN  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vote_en,
    input  vote_e            vote,
    output logic [LVL_W-1:0] level,
    output logic             level_upd
);
    localparam int SW = $clog2(STREAK_LEN + 1);
    localparam logic [LVL_W-1:0] LVL_TOP  = LVL_W'(MAX_LEVEL);
    localparam logic [LVL_W-1:0] LVL_INIT = LVL_W'(RESET_LEVEL);
    localparam logic [SW-1:0]    RUN_LAST = SW'(STREAK_LEN - 1);

    logic [LVL_W-1:0] level_q, level_d;
    logic [SW-1:0]    run_q, run_d;
    vote_e            dir_q, dir_d;
    logic             upd_q, upd_d;
    logic             blocked;

    always_comb begin
        blocked = ((vote == VOTE_DEC) && (level_q == '0)) ||
                  ((vote == VOTE_INC) && (level_q == LVL_TOP));
        level_d = level_q;
        run_d   = run_q;
        dir_d   = dir_q;
        upd_d   = 1'b0;
        if (vote_en && !blocked) begin
            if (vote == VOTE_HOLD) begin
                run_d = '0;
                dir_d = VOTE_HOLD;
            end else if (vote == dir_q) begin
                if (run_q == RUN_LAST) begin
                    level_d = (vote == VOTE_INC) ? level_q + 1'b1 : level_q - 1'b1;
                    run_d   = '0;
                    dir_d   = VOTE_HOLD;
                    upd_d   = 1'b1;
                end else begin
                    run_d = run_q + 1'b1;
                end
            end else begin
                dir_d = vote;
                run_d = SW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= LVL_INIT;
            run_q   <= '0;
            dir_q   <= VOTE_HOLD;
            upd_q   <= 1'b0;
        end else begin
            level_q <= level_d;
            run_q   <= run_d;
            dir_q   <= dir_d;
            upd_q   <= upd_d;
        end
    end

    assign level     = level_q;
    assign level_upd = upd_q;
endmodule

// File: rtl/repl_level_ctrl.sv
module repl_level_ctrl
    import repl_lvl_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int LAT_W       = 8,
    parameter int TRIG_COUNT  = 1024,
    parameter int MAX_LEVEL   = 5,
    parameter int RESET_LEVEL = 0,
    parameter int STREAK_LEN  = 4,
    localparam int LVL_W      = $clog2(MAX_LEVEL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_cur_replica,
    input  logic             hit_next_buf,
    input  logic             hit_victim_buf,
    input  logic             hit_lru_tail,
    input  logic             alloc_local_repl,
    input  logic             alloc_next_buf,
    input  logic [LAT_W-1:0] hit_lat_delta,
    input  logic [LAT_W-1:0] miss_penalty,
    output logic [LVL_W-1:0] repl_level,
    output logic             level_update
);
    ctl_state_e state_q, state_d;
    logic       fire;
    logic       armed, weigh_en, vote_en;
    vote_e      vote;

    logic [NUM_EV-1:0]            ev_vec;
    logic [NUM_EV-1:0][CNT_W-1:0] win_cnt;

    assign ev_vec[EV_BEN_LOSS]  = hit_cur_replica;
    assign ev_vec[EV_BEN_GAIN]  = hit_next_buf;
    assign ev_vec[EV_COST_SAVE] = hit_victim_buf;
    assign ev_vec[EV_COST_ADD]  = hit_lru_tail;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_COLLECT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLLECT: if (fire) state_d = ST_WEIGH;   // window close
            ST_WEIGH:   state_d = ST_VOTE;              // products ready
            ST_VOTE:    state_d = ST_COLLECT;           // vote applied
            default:    state_d = ST_COLLECT;
        endcase
    end

    // state outputs
    always_comb begin
        armed    = 1'b0;
        weigh_en = 1'b0;
        vote_en  = 1'b0;
        unique case (state_q)
            ST_COLLECT: armed    = 1'b1;
            ST_WEIGH:   weigh_en = 1'b1;
            ST_VOTE:    vote_en  = 1'b1;
            default:    armed    = 1'b0;
        endcase
    end

    repl_eval_trigger #(
        .TRIG_COUNT (TRIG_COUNT)
    ) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .alloc_a (alloc_local_repl),
        .alloc_b (alloc_next_buf),
        .armed   (armed),
        .fire    (fire)
    );

    for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
        repl_event_ctr #(
            .CNT_W (CNT_W)
        ) u_ctr (
            .clk       (clk),
            .rst_n     (rst_n),
            .ev        (ev_vec[e]),
            .close_win (fire),
            .win_total (win_cnt[e])
        );
    end

    repl_vote_unit #(
        .CNT_W (CNT_W),
        .LAT_W (LAT_W)
    ) u_vote (
        .clk      (clk),
        .rst_n    (rst_n),
        .weigh_en (weigh_en),
        .win_cnt  (win_cnt),
        .hit_lat  (hit_lat_delta),
        .miss_lat (miss_penalty),
        .vote     (vote)
    );

    repl_streak_ctrl #(
        .LVL_W       (LVL_W),
        .MAX_LEVEL   (MAX_LEVEL),
        .RESET_LEVEL (RESET_LEVEL),
        .STREAK_LEN  (STREAK_LEN)
    ) u_streak (
        .clk       (clk),
        .rst_n     (rst_n),
        .vote_en   (vote_en),
        .vote      (vote),
        .level     (repl_level),
        .level_upd (level_update)
    );
endmodule

// File: rtl/repl_level_chk.sv
module repl_level_chk
    import repl_lvl_pkg::*;
#(
    parameter int LVL_W     = 3,
    parameter int MAX_LEVEL = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] repl_level,
    input logic             level_update,
    input ctl_state_e       state_q
);
    // R6
    level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(repl_level) <= MAX_LEVEL);

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level_update |=> !level_update);

    // R7
    silent_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (repl_level != $past(repl_level)) |-> level_update);

    // R4
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level_update |-> ((repl_level == $past(repl_level) + 1'b1) ||
                          (repl_level + 1'b1 == $past(repl_level))));

    // R7
    pulse_after_vote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level_update |-> ($past(state_q) == ST_VOTE));

    // R2
    weigh_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WEIGH) |-> ($past(state_q) == ST_COLLECT));
endmodule

bind repl_level_ctrl repl_level_chk #(
    .LVL_W     (LVL_W),
    .MAX_LEVEL (MAX_LEVEL)
) u_level_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .repl_level   (repl_level),
    .level_update (level_update),
    .state_q      (state_q)
);

// File: tb/tb_repl_level_ctrl.sv
`timescale 1ns/1ps
module tb_repl_level_ctrl;
    localparam int CNT_W = 8;
    localparam int LAT_W = 8;
    localparam int CMAX  = (1 << CNT_W) - 1;
    localparam int LMAX  = 5;
    localparam int SLEN  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic h_cur = 0, h_nxt = 0, h_vic = 0, h_lru = 0;
    logic a_loc = 0, a_nxt = 0;
    logic [LAT_W-1:0] w_hit = 8'd4, w_miss = 8'd10;
    logic [2:0] lvl;
    logic upd;

    always #4 clk = ~clk;   // 125 MHz

    repl_level_ctrl #(.CNT_W(CNT_W), .LAT_W(LAT_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .hit_cur_replica(h_cur), .hit_next_buf(h_nxt),
        .hit_victim_buf(h_vic), .hit_lru_tail(h_lru),
        .alloc_local_repl(a_loc), .alloc_next_buf(a_nxt),
        .hit_lat_delta(w_hit), .miss_penalty(w_miss),
        .repl_level(lvl), .level_update(upd));

    int n_chk = 0, n_bad = 0;
    int exp_lvl = 0, exp_dir = 0, exp_run = 0;   // dir: 0 hold, 1 dec, 2 inc

    task automatic report_end();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int sat(int x);
        return (x > CMAX) ? CMAX : x;
    endfunction

    // R3 vote from window totals
    function automatic int calc_vote(int c, int n, int v, int l);
        bit d, i;
        d = sat(v) * int'(w_miss) > sat(c) * int'(w_hit);
        i = sat(n) * int'(w_hit)  > sat(l) * int'(w_miss);
        if (d && !i) return 1;
        if (i && !d) return 2;
        return 0;
    endfunction

    // R4 R5 R6 streak model
    task automatic apply_vote(int vt, output bit chg);
        chg = 0;
        if ((vt == 1 && exp_lvl == 0) || (vt == 2 && exp_lvl == LMAX)) return;
        if (vt == 0) begin exp_run = 0; exp_dir = 0; end
        else if (vt == exp_dir) begin
            if (exp_run == SLEN - 1) begin
                exp_lvl += (vt == 2) ? 1 : -1;
                exp_run = 0; exp_dir = 0; chg = 1;
            end else exp_run++;
        end else begin exp_dir = vt; exp_run = 1; end
    endtask

    task automatic drive(bit c, bit n, bit v, bit l, bit a, bit b);
        h_cur = c; h_nxt = n; h_vic = v; h_lru = l; a_loc = a; a_nxt = b;
    endtask

    // called right after the closing strobe was driven at a negedge
    task automatic finish_window(int vt, string tag);
        bit chg;
        int old;
        old = exp_lvl;
        apply_vote(vt, chg);
        @(negedge clk); drive(0,0,0,0,0,0);
        @(negedge clk);
        chk({tag, " R7 level before vote"}, int'(lvl), old);
        chk({tag, " R7 no early pulse"}, int'(upd), 0);
        @(negedge clk);
        chk({tag, " level after vote"}, int'(lvl), exp_lvl);
        chk({tag, " R7 pulse"}, int'(upd), int'(chg));
        @(negedge clk);
        chk({tag, " R7 pulse ends"}, int'(upd), 0);
    endtask

    task automatic run_window(int c, int n, int v, int l, bit dual, string tag);
        int mx, na;
        mx = c; if (n > mx) mx = n; if (v > mx) mx = v; if (l > mx) mx = l;
        for (int i = 0; i < mx; i++) begin
            @(negedge clk); drive(i < c, i < n, i < v, i < l, 0, 0);
        end
        na = dual ? 512 : 1024;
        for (int i = 0; i < na; i++) begin
            @(negedge clk); drive(0, 0, 0, 0, 1, dual);
        end
        finish_window(calc_vote(c, n, v, l), tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 level in reset", int'(lvl), 0);
        chk("R1 pulse in reset", int'(upd), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 level after reset", int'(lvl), 0);
        chk("R1 pulse after reset", int'(upd), 0);
    endtask

    task automatic t_floor();
        repeat (3) run_window(0, 5, 0, 0, 0, "R4 inc");
        repeat (2) run_window(0, 0, 5, 0, 0, "R6 dec at floor ignored");
        run_window(0, 5, 0, 0, 0, "R6 streak kept, R4 fourth inc");
        chk("R6 floor then rise", int'(lvl), 1);
    endtask

    task automatic t_hold_reset();
        repeat (3) run_window(0, 5, 0, 0, 0, "R5 inc");
        run_window(0, 0, 0, 0, 0, "R5 hold");
        repeat (3) run_window(0, 5, 0, 0, 0, "R5 inc after hold");
        run_window(0, 5, 0, 0, 0, "R5 fourth inc");
        chk("R5 level after hold test", int'(lvl), 2);
    endtask

    task automatic t_opposite();
        repeat (3) run_window(0, 5, 0, 0, 0, "R5 inc");
        repeat (3) run_window(0, 0, 5, 0, 0, "R5 opposite dec");
        run_window(0, 0, 5, 0, 0, "R5 fourth dec");
        chk("R5 level after opposite test", int'(lvl), 1);
    endtask

    task automatic t_weights();
        w_hit = 8'd1; w_miss = 8'd10;
        repeat (3) run_window(10, 0, 2, 0, 0, "R3 weighted dec");
        w_hit = 8'd5; w_miss = 8'd2;
        run_window(10, 0, 2, 0, 0, "R3 reweighted hold");
        w_hit = 8'd4; w_miss = 8'd4;
        run_window(5, 0, 5, 0, 0, "R3 equal products hold");
        run_window(0, 10, 10, 0, 0, "R3 both wanted hold");
        w_hit = 8'd1; w_miss = 8'd10;
        repeat (4) run_window(10, 0, 2, 0, 0, "R3 dec streak");
        chk("R3 level after weights", int'(lvl), 0);
        w_hit = 8'd4; w_miss = 8'd10;
    endtask

    task automatic t_trigger_edge();
        repeat (4) run_window(0, 5, 0, 0, 0, "R2 setup inc");
        repeat (3) run_window(0, 0, 5, 0, 0, "R8 setup dec");
        for (int i = 0; i < 1023; i++) begin
            @(negedge clk); drive(0, 0, 0, 0, 1, 0);
        end
        @(negedge clk); drive(0, 0, 0, 0, 0, 0);
        repeat (5) @(negedge clk);
        chk("R2 no evaluation at 1023", int'(lvl), 1);
        chk("R2 no pulse at 1023", int'(upd), 0);
        @(negedge clk); drive(0, 0, 1, 0, 1, 0);   // hit in closing cycle
        finish_window(calc_vote(0, 0, 1, 0), "R8 hit on closing cycle");
        chk("R8 level after edge test", int'(lvl), 0);
    endtask

    task automatic t_saturate();
        w_hit = 8'd1; w_miss = 8'd1;
        repeat (3) run_window(0, 5, 0, 0, 0, "R9 inc");
        run_window(0, 300, 0, 256, 0, "R9 saturated tie hold");
        repeat (3) run_window(0, 5, 0, 0, 0, "R9 inc after hold");
        chk("R9 level still low", int'(lvl), 0);
        run_window(0, 5, 0, 0, 0, "R9 fourth inc");
        chk("R9 level after saturation test", int'(lvl), 1);
        w_hit = 8'd4; w_miss = 8'd10;
    endtask

    task automatic t_ceiling();
        for (int k = 0; k < 24 && exp_lvl < LMAX; k++)
            run_window(0, 5, 0, 0, k[0], "R2 climb dual/single");
        chk("R6 reached top", int'(lvl), 5);
        repeat (2) run_window(0, 5, 0, 0, 1, "R6 inc at top ignored");
        repeat (3) run_window(0, 0, 5, 0, 0, "R6 dec");
        repeat (2) run_window(0, 5, 0, 0, 0, "R6 inc at top ignored");
        run_window(0, 0, 5, 0, 1, "R6 fourth dec");
        chk("R6 level after ceiling test", int'(lvl), 4);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report_end();
    end

    initial begin
        t_reset();
        t_floor();
        t_hold_reset();
        t_opposite();
        t_weights();
        t_trigger_edge();
        t_saturate();
        t_ceiling();
        report_end();
    end
endmodule